// File: doc/BRIEF.md
# Serial-Programmed Rate and Pulse-Mode Configurator

This block sits between a UART transmit line and the timing logic of an infrared pulse encoder/decoder. While a programming select input is high, every character that arrives on the serial input is taken as a configuration word instead of as data. The block captures that word at the bit rate already in force. It then splits the word into four settings: a rate code, a pulse-width mode flag, and two general-purpose control outputs.

The captured settings are held in a pending copy. They reach the outputs only on the cycle after the programming select falls, so the rate used to receive the word cannot change partway through a window. The rate appears as a divisor: the number of 32-clock units in one bit period of the reference clock. An active-high reset restores the defaults, which are 9600 bit/s, the fixed short pulse and both user outputs inactive. Reset also drives an active-low shutdown output for the transceiver.

Top module: `irlink_cfg`

## Requirements
- R1: While `prog_sel` is high, a frame on `ser_in` is received. The frame is one low start bit, eight data bits sent least significant bit first, and one stop bit. Every bit lasts `rate_div`×32 clock cycles, where `rate_div` is the value currently applied.
- R2: Word bits [3:0] are the rate code. Codes 0x0 to 0xC give `rate_div` values of 1, 2, 3, 6, 8, 9, 12, 16, 24, 32, 48, 64 and 96, in code order. These correspond to 115.2k down to 1.2k bit/s.
- R3: Word bit 4 sets `short_pulse`. A 1 selects the fixed 1.627 µs pulse and a 0 selects a pulse of 3/16 of the bit time.
- R4: Word bit 5 drives `user1_n` and word bit 6 drives `user2_n`. Both outputs are active low, so a 1 in the word makes the output 0. Word bit 7 has no effect.
- R5: Outputs change only on the clock edge after `prog_sel` goes from high to low. They stay stable while the window is open.
- R6: Reset (`rst` high) forces `rate_div`=12, `short_pulse`=1, `user1_n`=1 and `user2_n`=1. These values are kept after reset is released.
- R7: `shdn_n` is always the inverse of `rst`.
- R8: A word whose rate code is 0xD, 0xE or 0xF keeps the previous rate. Its pulse and user bits still apply.
- R9: A frame whose stop bit is sampled low is discarded completely.
- R10: If several valid words arrive in one programming window, the last one is the one applied.
- R11: Frames sent while `prog_sel` is low have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 32 cycles per bit at the fastest rate |
| rst | input | 1 | Asynchronous reset, active high |
| prog_sel | input | 1 | High opens a programming window; its falling edge applies the settings |
| ser_in | input | 1 | UART transmit line, idle high |
| rate_div | output | DIVW | Bit period in units of 32 clocks |
| short_pulse | output | 1 | 1: fixed short pulse, 0: 3/16-bit pulse |
| user1_n | output | 1 | General-purpose output 1, active low |
| user2_n | output | 1 | General-purpose output 2, active low |
| shdn_n | output | 1 | Transceiver shutdown, inverse of reset |

## Verification
The hardest case to reach is a word received at a rate that the previous word selected. Any error in the bit timing shows up only once the rate has actually changed. The vector table therefore chains its windows. Each word is sent at the rate committed by the entry before it, and the chain covers the slowest and fastest divisors plus forbidden codes. Directed windows then send two words back to back, a frame with a low stop bit, and a frame with the select low. After each of these, the outputs are read back and compared with the expected settings.

// File: rtl/irlink_cfg.sv
module irlink_cfg #(
  parameter int BASE_CLKS = 32,
  parameter int DIVW      = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            prog_sel,
  input  logic            ser_in,
  output logic [DIVW-1:0] rate_div,
  output logic            short_pulse,
  output logic            user1_n,
  output logic            user2_n,
  output logic            shdn_n
);
  localparam int MAXDIV = 96;
  localparam int CW = $clog2(MAXDIV * BASE_CLKS + 1);
  localparam logic [3:0] MAX_CODE = 4'hC;

  typedef struct packed {
    logic [3:0] code;
    logic       shrt;
    logic       u1;
    logic       u2;
  } cfg_t;
  localparam cfg_t DEF_CFG = '{code: 4'h6, shrt: 1'b1, u1: 1'b0, u2: 1'b0};

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_BREAK} rx_t;

  function automatic logic [DIVW-1:0] code2div(input logic [3:0] c);
    case (c)
      4'h0: return DIVW'(1);
      4'h1: return DIVW'(2);
      4'h2: return DIVW'(3);
      4'h3: return DIVW'(6);
      4'h4: return DIVW'(8);
      4'h5: return DIVW'(9);
      4'h6: return DIVW'(12);
      4'h7: return DIVW'(16);
      4'h8: return DIVW'(24);
      4'h9: return DIVW'(32);
      4'hA: return DIVW'(48);
      4'hB: return DIVW'(64);
      4'hC: return DIVW'(96);
      default: return DIVW'(12);
    endcase
  endfunction

  cfg_t         act, pend;
  logic         prog_q;
  logic [1:0]   sync;
  logic         rx;
  rx_t          st;
  logic [CW-1:0] cnt, per;
  logic [2:0]   bitn;
  logic [7:0]   shreg;
  logic         got;
  logic [7:0]   word;

  assign rx          = sync[1];
  assign rate_div    = code2div(act.code);
  assign per         = CW'(rate_div) * CW'(BASE_CLKS);
  assign short_pulse = act.shrt;
  assign user1_n     = ~act.u1;
  assign user2_n     = ~act.u2;
  assign shdn_n      = ~rst;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sync  <= 2'b11;
      st    <= S_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      got   <= 1'b0;
      word  <= '0;
    end else begin
      sync <= {sync[0], ser_in};
      got  <= 1'b0;
      if (!prog_sel) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE:
            if (!rx) begin
              st  <= S_START;
              cnt <= (per >> 1) - CW'(1);
            end
          S_START:
            if (cnt == '0) begin
              st   <= rx ? S_IDLE : S_DATA;
              cnt  <= per - CW'(1);
              bitn <= '0;
            end else cnt <= cnt - CW'(1);
          S_DATA:
            if (cnt == '0) begin
              shreg <= {rx, shreg[7:1]};
              bitn  <= bitn + 3'd1;
              cnt   <= per - CW'(1);
              if (bitn == 3'd7) st <= S_STOP;
            end else cnt <= cnt - CW'(1);
          S_STOP:
            if (cnt == '0) begin
              if (rx) begin
                got  <= 1'b1;
                word <= shreg;
                st   <= S_IDLE;
              end else st <= S_BREAK;
            end else cnt <= cnt - CW'(1);
          S_BREAK:
            if (rx) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      act    <= DEF_CFG;
      pend   <= DEF_CFG;
      prog_q <= 1'b0;
    end else begin
      prog_q <= prog_sel;
      if (prog_q && !prog_sel) begin
        act <= pend;
      end else if (!prog_sel) begin
        pend <= act;
      end else if (got) begin
        if (word[3:0] <= MAX_CODE) pend.code <= word[3:0];
        pend.shrt <= word[4];
        pend.u1   <= word[5];
        pend.u2   <= word[6];
      end
    end
  end
endmodule

module irlink_cfg_chk #(
  parameter int DIVW = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            prog_sel,
  input logic [DIVW-1:0] rate_div,
  input logic            short_pulse,
  input logic            user1_n,
  input logic            user2_n
);
  assert_legal_div_R2: assert property (@(posedge clk) disable iff (rst)
    rate_div inside {1, 2, 3, 6, 8, 9, 12, 16, 24, 32, 48, 64, 96});

  assert_rate_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !($past(prog_sel) && !prog_sel) |=> ($stable(rate_div) && $stable(short_pulse)));

  assert_user_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !($past(prog_sel) && !prog_sel) |=> ($stable(user1_n) && $stable(user2_n)));

  assert_reset_defaults_R6: assert property (@(posedge clk)
    rst |=> (rate_div == DIVW'(12) && short_pulse && user1_n && user2_n));
endmodule

bind irlink_cfg irlink_cfg_chk #(.DIVW(DIVW)) u_chk (
  .clk(clk), .rst(rst), .prog_sel(prog_sel), .rate_div(rate_div),
  .short_pulse(short_pulse), .user1_n(user1_n), .user2_n(user2_n)
);

// File: tb/irlink_cfg_bench.sv
module irlink_cfg_bench;
  localparam int DIVW = 7;
  localparam int BASE = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prog_sel = 1'b0;
  logic ser_in = 1'b1;
  logic [DIVW-1:0] rate_div;
  logic short_pulse, user1_n, user2_n, shdn_n;

  int checks = 0;
  int fails = 0;
  int cur_div = 12;
  bit done = 0;

  always #2.5 clk = ~clk;

  irlink_cfg #(.BASE_CLKS(BASE), .DIVW(DIVW)) u_irlink_cfg (
    .clk(clk), .rst(rst), .prog_sel(prog_sel), .ser_in(ser_in),
    .rate_div(rate_div), .short_pulse(short_pulse),
    .user1_n(user1_n), .user2_n(user2_n), .shdn_n(shdn_n)
  );

  // {word, div, short, user1_n, user2_n}; each word is sent at the previous entry's rate
  localparam logic [17:0] VEC [9] = '{
    {8'h36, 7'd12, 1'b1, 1'b0, 1'b1},
    {8'h00, 7'd1,  1'b0, 1'b1, 1'b1},
    {8'h51, 7'd2,  1'b1, 1'b1, 1'b0},
    {8'h9F, 7'd2,  1'b1, 1'b1, 1'b1},
    {8'h0D, 7'd2,  1'b0, 1'b1, 1'b1},
    {8'h65, 7'd9,  1'b0, 1'b0, 1'b0},
    {8'h0C, 7'd96, 1'b0, 1'b1, 1'b1},
    {8'h02, 7'd3,  1'b0, 1'b1, 1'b1},
    {8'h16, 7'd12, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_cfg(input string req, input int d, input int s, input int a, input int b);
    chk({req, " div"}, int'(rate_div), d);
    chk({req, " short"}, int'(short_pulse), s);
    chk({req, " user1_n"}, int'(user1_n), a);
    chk({req, " user2_n"}, int'(user2_n), b);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop, input int div);
    int bt;
    bt = div * BASE;
    @(negedge clk) ser_in = 1'b0;
    repeat (bt) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      ser_in = b[i];
      repeat (bt) @(negedge clk);
    end
    ser_in = stop;
    repeat (bt) @(negedge clk);
    ser_in = 1'b1;
    repeat (bt) @(negedge clk);
  endtask

  task automatic open_win();
    @(negedge clk) prog_sel = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic close_win();
    @(negedge clk) prog_sel = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R6 R7: defaults and shutdown while in reset
    chk("R7 shdn in reset", int'(shdn_n), 0);
    chk_cfg("R6 reset", 12, 1, 1, 1);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7 shdn after reset", int'(shdn_n), 1);
    chk_cfg("R6 after release", 12, 1, 1, 1);

    // R1 R2 R3 R4 R8 R5: chained vector table
    for (int v = 0; v < 9; v++) begin
      logic [17:0] e;
      e = VEC[v];
      open_win();
      send_frame(e[17:10], 1'b1, cur_div);
      repeat (20) @(negedge clk);
      chk("R5 held before fall", int'(rate_div), cur_div);
      close_win();
      chk_cfg("R1 R2 R3 R4 R8 vector", int'(e[9:3]), int'(e[2]), int'(e[1]), int'(e[0]));
      cur_div = int'(e[9:3]);
    end

    // R10: last valid word in the window wins
    open_win();
    send_frame(8'h03, 1'b1, cur_div);
    send_frame(8'h25, 1'b1, cur_div);
    chk("R5 held with two words", int'(rate_div), 12);
    close_win();
    chk_cfg("R10 last wins", 9, 0, 0, 1);
    cur_div = 9;

    // R9: low stop bit discards the frame
    open_win();
    send_frame(8'h40, 1'b0, cur_div);
    repeat (20) @(negedge clk);
    close_win();
    chk_cfg("R9 bad stop", 9, 0, 0, 1);

    // R11: frames with select low are ignored
    send_frame(8'h40, 1'b1, cur_div);
    repeat (20) @(negedge clk);
    chk_cfg("R11 select low", 9, 0, 0, 1);
    open_win();
    close_win();
    chk_cfg("R11 empty window", 9, 0, 0, 1);

    // R6 R7: reset after programming
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7 shdn reasserted", int'(shdn_n), 0);
    chk_cfg("R6 reprogrammed reset", 12, 1, 1, 1);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 shdn released", int'(shdn_n), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule